// File: doc/BRIEF.md
# PC Card Attribute Configuration Registers

This block is the attribute-memory face of a 16-bit PC Card storage device. A host reaches it through a byte-wide port with an address, a strobe and a write flag. Addresses below a configurable attribute base return bytes of the card information structure. That structure is a parameter of the block. At and above the base, four configuration registers are decoded at even offsets. The option register is at +0, configuration status at +2, pin replacement at +4 and socket/copy at +6.

The block also produces the card interrupt request. It combines the interrupt line of the attached drive with the device-control byte written from the I/O side. The interrupt request is inverted with respect to the internal status flag. It is asserted only while that flag is clear and nothing blocks it. Soft reset can be triggered either from the option register or from device control.

Top module: `pccfg_attr_top`

## Requirements
- R1: A read strobe returns its byte on `attr_rdata` one cycle later, and the byte holds until the next read. At the base, offsets +0 (option), +2 (status) and +4 (pin replacement) are decoded. Offset +6 (socket/copy) always reads 0x00 and ignores writes. Odd offsets and offsets of +8 or more read 0x00.
- R2: A read below the attribute base returns byte `a` of the information structure, with byte 0 in bits [7:0] of the parameter. An address at or beyond the structure length returns 0x00.
- R3: A write to the option register stores the written value ANDed with 0xCF, and a read returns that stored value.
- R4: A write to the status register keeps the current bits under 0x82 and loads bits 0x74 from the written value.
- R5: A status write whose bit 2 (power-down) differs from the stored bit 2 sets the ready flag, bit 5 of the pin register. The flag then stays set until a soft or hardware reset.
- R6: A pin replacement read returns the ready flag (bit 5) ORed with 0x0C. A write keeps the ready flag, loads only bit 1, and never changes the value read back.
- R7: Status bit 1 follows `drv_irq`, one cycle after the input changes.
- R8: A status read shows bit 1 as 0 whenever device-control bit 1 is set.
- R9: `card_irq` is high exactly when status bit 1, device-control bits 1 and 2, and option bit 7 are all 0. It changes one cycle after the write or `drv_irq` change that causes it.
- R10: An option write with bit 7 set clears the status register (except bit 1, which follows the drive), the pin register and device control. The option register keeps the written value ANDed with 0xCF, so bit 7 stays set.
- R11: A device-control write with bit 2 set clears the option, status and pin registers. Status bit 1 still follows the drive. Device control keeps the written value.
- R12: After hardware reset, option, status and device control read 0x00 and pin replacement reads 0x0C. With `drv_irq` low, `card_irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| attr_en | input | 1 | Attribute access strobe |
| attr_we | input | 1 | 1 = write, 0 = read |
| attr_addr | input | ADDR_W | Attribute byte address |
| attr_wdata | input | 8 | Write data |
| attr_rdata | output | 8 | Read data, valid the cycle after a read |
| ctl_we | input | 1 | Device-control write strobe from the I/O side |
| ctl_wdata | input | 8 | Device-control value |
| drv_irq | input | 1 | Interrupt line of the attached drive |
| card_irq | output | 1 | Registered card interrupt request |

## Verification
The hardest situation to reach is a power-down toggle that sets the ready flag, followed by a soft reset that must clear it again. The flag is only visible through the pin register, and it can only be set by a status write whose bit 2 differs from the stored bit. The stimulus therefore first writes the status register to set power-down, which raises the flag. It then issues each kind of soft reset, option bit 7 and then device-control bit 2. After each one it reads the pin register back and watches `card_irq` for the blocking bit that the reset leaves behind.

// File: rtl/pccfg_pkg.sv
// Package: shared constants and select type for the attribute
// configuration block. Assumes byte-wide registers.
package pccfg_pkg;

    localparam logic [7:0] OPT_STORE_MASK = 8'hCF;
    localparam logic [7:0] STAT_HOLD_MASK = 8'h82;
    localparam logic [7:0] STAT_LOAD_MASK = 8'h74;
    localparam logic [7:0] PIN_LOAD_MASK  = 8'h02;
    localparam logic [7:0] PIN_RD_CONST   = 8'h0C;
    localparam int         STAT_INT_BIT   = 1;
    localparam int         STAT_PWR_BIT   = 2;
    localparam int         PIN_READY_BIT  = 5;
    localparam int         CTL_IRQOFF_BIT = 1;
    localparam int         CTL_SRST_BIT   = 2;
    localparam int         OPT_SRST_BIT   = 7;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CIS,
        SEL_OPT,
        SEL_STAT,
        SEL_PIN,
        SEL_SOCK
    } attr_sel_e;

endpackage

// File: rtl/pccfg_decode.sv
// Module: attribute address decoder.
// Maps an address to the information-structure ROM or one of the
// four registers. Only even offsets below +8 at the base are registers.
module pccfg_decode
    import pccfg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int ATTR_BASE = 'h200
) (
    input  logic [ADDR_W-1:0] addr,
    output attr_sel_e         sel
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ATTR_BASE);

    logic [ADDR_W-1:0] ofs;

    // Offset from the base and the region selection.
    always_comb begin
        ofs = addr - BASE;
        sel = SEL_NONE;
        if (addr < BASE) begin
            sel = SEL_CIS;
        end else if (ofs[ADDR_W-1:3] == '0 && !ofs[0]) begin
            case (ofs[2:1])
                2'd0:    sel = SEL_OPT;
                2'd1:    sel = SEL_STAT;
                2'd2:    sel = SEL_PIN;
                default: sel = SEL_SOCK;
            endcase
        end
    end
endmodule

// File: rtl/pccfg_cis_rom.sv
// Module: card information structure lookup.
// Byte i of the ROM sits in CIS_BYTES[8*i +: 8]. Addresses at or
// beyond CIS_LEN return zero.
module pccfg_cis_rom #(
    parameter int                  ADDR_W    = 12,
    parameter int                  CIS_LEN   = 12,
    parameter logic [CIS_LEN*8-1:0] CIS_BYTES = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        rom_byte
);
    // Select the byte whose index equals the address.
    always_comb begin
        rom_byte = 8'h00;
        for (int i = 0; i < CIS_LEN; i++) begin
            if (addr == ADDR_W'(i)) rom_byte = CIS_BYTES[i*8 +: 8];
        end
    end
endmodule

// File: rtl/pccfg_regs.sv
// Module: option, status, pin replacement and device-control state.
// Applies the write masks, the ready-flag rule and both soft resets.
// Assumes at most one attribute write per cycle. A device-control write
// in the same cycle takes effect after it.
module pccfg_regs
    import pccfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_opt,
    input  logic       wr_stat,
    input  logic       wr_pin,
    input  logic [7:0] wdata,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       drv_irq,
    output logic [7:0] opt_q,
    output logic [7:0] stat_q,
    output logic       ready_q,
    output logic [7:0] ctl_q,
    output logic       irq_blk_d,
    output logic       stat_int_d
);
    logic [7:0] opt_d, stat_d, pin_d, ctl_d, pin_q;
    logic       soft_rst;

    assign soft_rst = (wr_opt && wdata[OPT_SRST_BIT]) ||
                      (ctl_we && ctl_wdata[CTL_SRST_BIT]);

    // Next-state rules for all four registers.
    always_comb begin
        opt_d  = opt_q;
        stat_d = stat_q;
        pin_d  = pin_q;
        ctl_d  = ctl_q;
        if (wr_stat) begin
            if (stat_q[STAT_PWR_BIT] != wdata[STAT_PWR_BIT])
                pin_d[PIN_READY_BIT] = 1'b1;
            stat_d = (stat_q & STAT_HOLD_MASK) | (wdata & STAT_LOAD_MASK);
        end
        if (wr_pin)
            pin_d = (pin_q & (8'h01 << PIN_READY_BIT)) | (wdata & PIN_LOAD_MASK);
        if (wr_opt) begin
            opt_d = wdata & OPT_STORE_MASK;
            if (wdata[OPT_SRST_BIT]) begin
                stat_d = '0;
                pin_d  = '0;
                ctl_d  = '0;
            end
        end
        if (ctl_we) begin
            ctl_d = ctl_wdata;
            if (ctl_wdata[CTL_SRST_BIT]) begin
                opt_d  = '0;
                stat_d = '0;
                pin_d  = '0;
            end
        end
        stat_d[STAT_INT_BIT] = drv_irq;
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_q  <= '0;
            stat_q <= '0;
            pin_q  <= '0;
            ctl_q  <= '0;
        end else begin
            opt_q  <= opt_d;
            stat_q <= stat_d;
            pin_q  <= pin_d;
            ctl_q  <= ctl_d;
        end
    end

    assign ready_q    = pin_q[PIN_READY_BIT];
    assign stat_int_d = stat_d[STAT_INT_BIT];
    assign irq_blk_d  = ctl_d[CTL_IRQOFF_BIT] | ctl_d[CTL_SRST_BIT] | opt_d[OPT_SRST_BIT];

    // R7: status bit 1 tracks the drive line with one cycle of delay.
    a_r7_drive_track: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> stat_q[STAT_INT_BIT] == $past(drv_irq));

    // R5: the ready flag is sticky until a soft reset.
    a_r5_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_q[PIN_READY_BIT] && !soft_rst) |=> pin_q[PIN_READY_BIT]);

    // R4: a plain status write loads the accepted bits.
    a_r4_stat_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !soft_rst) |=> (stat_q & STAT_LOAD_MASK) == ($past(wdata) & STAT_LOAD_MASK));

    // R3: the masked-off option bits never become set.
    a_r3_opt_mask: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (opt_q & ~OPT_STORE_MASK) == 8'h00);
endmodule

// File: rtl/pccfg_irq_gate.sv
// Module: card interrupt request register.
// Drives the request high when neither the status interrupt flag nor a
// blocking bit will be set after this edge. Reset value matches the
// all-zero register state.
module pccfg_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_int_d,
    input  logic irq_blk_d,
    output logic card_irq
);
    // Register the gated request from the next register state.
    always_ff @(posedge clk) begin
        if (!rst_n) card_irq <= 1'b1;
        else        card_irq <= !(stat_int_d || irq_blk_d);
    end
endmodule

// File: rtl/pccfg_attr_top.sv
// Module: PC Card attribute configuration register file (top).
// Decodes byte accesses, returns ROM or register bytes one cycle after
// a read strobe, and produces the card interrupt request.
// Assumes the host holds attr_en for one cycle per access.
module pccfg_attr_top
    import pccfg_pkg::*;
#(
    parameter int                  ADDR_W    = 12,
    parameter int                  ATTR_BASE = 'h200,
    parameter int                  CIS_LEN   = 12,
    parameter logic [CIS_LEN*8-1:0] CIS_BYTES = 96'hFF_14_00_20_1A_00_DB_03_00_0D_03_01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              attr_en,
    input  logic              attr_we,
    input  logic [ADDR_W-1:0] attr_addr,
    input  logic [7:0]        attr_wdata,
    output logic [7:0]        attr_rdata,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              drv_irq,
    output logic              card_irq
);
    attr_sel_e  sel;
    logic [7:0] rom_byte, opt_q, stat_q, ctl_q, rd_byte;
    logic       ready_q, irq_blk_d, stat_int_d;
    logic       wr_opt, wr_stat, wr_pin, rd_en;

    pccfg_decode #(.ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE)) u_decode (
        .addr (attr_addr),
        .sel  (sel)
    );

    pccfg_cis_rom #(.ADDR_W(ADDR_W), .CIS_LEN(CIS_LEN), .CIS_BYTES(CIS_BYTES)) u_rom (
        .addr     (attr_addr),
        .rom_byte (rom_byte)
    );

    assign wr_opt  = attr_en && attr_we && sel == SEL_OPT;
    assign wr_stat = attr_en && attr_we && sel == SEL_STAT;
    assign wr_pin  = attr_en && attr_we && sel == SEL_PIN;
    assign rd_en   = attr_en && !attr_we;

    pccfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_opt     (wr_opt),
        .wr_stat    (wr_stat),
        .wr_pin     (wr_pin),
        .wdata      (attr_wdata),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .drv_irq    (drv_irq),
        .opt_q      (opt_q),
        .stat_q     (stat_q),
        .ready_q    (ready_q),
        .ctl_q      (ctl_q),
        .irq_blk_d  (irq_blk_d),
        .stat_int_d (stat_int_d)
    );

    pccfg_irq_gate u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_int_d (stat_int_d),
        .irq_blk_d  (irq_blk_d),
        .card_irq   (card_irq)
    );

    // Read multiplexer for the selected region.
    always_comb begin
        case (sel)
            SEL_CIS:  rd_byte = rom_byte;
            SEL_OPT:  rd_byte = opt_q;
            SEL_STAT: rd_byte = ctl_q[CTL_IRQOFF_BIT] ?
                                (stat_q & ~(8'h01 << STAT_INT_BIT)) : stat_q;
            SEL_PIN:  rd_byte = PIN_RD_CONST | (8'(ready_q) << PIN_READY_BIT);
            default:  rd_byte = 8'h00;
        endcase
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     attr_rdata <= 8'h00;
        else if (rd_en) attr_rdata <= rd_byte;
    end

    // R9: interrupt request agrees with the register state.
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        card_irq == !(stat_q[STAT_INT_BIT] || ctl_q[CTL_IRQOFF_BIT] ||
                      ctl_q[CTL_SRST_BIT] || opt_q[OPT_SRST_BIT]));

    // R1: socket/copy reads return zero.
    a_r1_sock_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_SOCK) |=> attr_rdata == 8'h00);

    // R8: status bit 1 is hidden while device control bit 1 is set.
    a_r8_stat_hide: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_STAT && ctl_q[CTL_IRQOFF_BIT]) |=> !attr_rdata[STAT_INT_BIT]);
endmodule

// File: tb/test_pccfg_attr_top.sv
`timescale 1ns/1ps
module test_pccfg_attr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        attr_en = 1'b0, attr_we = 1'b0;
    logic [11:0] attr_addr = '0;
    logic [7:0]  attr_wdata = '0;
    logic [7:0]  attr_rdata;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic        drv_irq = 1'b0;
    logic        card_irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    pccfg_attr_top i_pccfg_attr_top (
        .clk(clk), .rst_n(rst_n), .attr_en(attr_en), .attr_we(attr_we),
        .attr_addr(attr_addr), .attr_wdata(attr_wdata), .attr_rdata(attr_rdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .drv_irq(drv_irq), .card_irq(card_irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic awrite(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        attr_en = 1'b1; attr_we = 1'b1; attr_addr = a; attr_wdata = d;
        @(negedge clk);
        attr_en = 1'b0; attr_we = 1'b0;
    endtask

    // Driver: issue a read and push its expected byte for the monitor.
    task automatic aread(input logic [11:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        attr_en = 1'b1; attr_we = 1'b0; attr_addr = a;
        @(negedge clk);
        attr_en = 1'b0;
    endtask

    task automatic cwrite(input logic [7:0] d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    // Set the drive line and check the request one cycle later.
    task automatic set_drv(input logic v);
        @(negedge clk);
        drv_irq = v;
        @(negedge clk);
    endtask

    // Monitor: pop and compare read data one step after the capturing edge.
    always begin
        @(posedge clk);
        if (rst_n && attr_en && !attr_we) begin
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), attr_rdata, exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 irq after reset", {7'd0, card_irq}, 8'h01);
        aread(12'h200, 8'h00, "R12 option reset");
        aread(12'h202, 8'h00, "R12 status reset");
        aread(12'h204, 8'h0C, "R12 pin reset");
        // ROM region
        aread(12'h000, 8'h01, "R2 rom byte 0");
        aread(12'h002, 8'h0D, "R2 rom byte 2");
        aread(12'h00B, 8'hFF, "R2 rom last byte");
        aread(12'h00C, 8'h00, "R2 beyond length");
        aread(12'h1FF, 8'h00, "R2 just below base");
        // Option mask
        awrite(12'h200, 8'h3F);
        aread(12'h200, 8'h0F, "R3 option mask");
        // Status write and power-down toggle
        awrite(12'h202, 8'hFF);
        aread(12'h202, 8'h74, "R4 status load");
        aread(12'h204, 8'h2C, "R5 ready set on toggle");
        awrite(12'h202, 8'h04);
        aread(12'h202, 8'h04, "R4 status reload");
        awrite(12'h204, 8'h00);
        aread(12'h204, 8'h2C, "R6 pin write keeps ready");
        awrite(12'h204, 8'hFF);
        aread(12'h204, 8'h2C, "R6 pin write bits invisible");
        // Drive interrupt
        set_drv(1'b1);
        check("R9 irq drops with drive", {7'd0, card_irq}, 8'h00);
        aread(12'h202, 8'h06, "R7 status follows drive");
        cwrite(8'h02);
        aread(12'h202, 8'h04, "R8 status int hidden");
        set_drv(1'b0);
        check("R9 irq blocked by ctl bit 1", {7'd0, card_irq}, 8'h00);
        cwrite(8'h00);
        check("R9 irq returns", {7'd0, card_irq}, 8'h01);
        // Socket, odd and out-of-range offsets
        awrite(12'h206, 8'hFF);
        aread(12'h206, 8'h00, "R1 socket reads zero");
        aread(12'h201, 8'h00, "R1 odd offset zero");
        aread(12'h208, 8'h00, "R1 offset past registers");
        aread(12'h200, 8'h0F, "R1 option unchanged after socket write");
        // Soft reset through option
        cwrite(8'h02);
        awrite(12'h200, 8'h81);
        check("R10 irq blocked by option bit 7", {7'd0, card_irq}, 8'h00);
        aread(12'h200, 8'h81, "R10 option keeps value");
        aread(12'h202, 8'h00, "R10 status cleared");
        aread(12'h204, 8'h0C, "R10 ready cleared");
        awrite(12'h200, 8'h00);
        check("R10 device control cleared", {7'd0, card_irq}, 8'h01);
        // Soft reset through device control
        awrite(12'h200, 8'h03);
        awrite(12'h202, 8'h04);
        aread(12'h204, 8'h2C, "R5 ready set again");
        cwrite(8'h04);
        check("R11 irq blocked by ctl bit 2", {7'd0, card_irq}, 8'h00);
        aread(12'h200, 8'h00, "R11 option cleared");
        aread(12'h202, 8'h00, "R11 status cleared");
        aread(12'h204, 8'h0C, "R11 ready cleared");
        cwrite(8'h00);
        check("R11 irq after ctl cleared", {7'd0, card_irq}, 8'h01);
        repeat (3) @(negedge clk);
        check("R1 all reads compared", 8'(exp_q.size()), 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule